// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the processor-side control that turns an interrupt taken from the interrupt controller into a change of control flow, and reverses it on return. It keeps a program counter, a status word, a saved return address, a saved status word and a cause register. When the controller presents an accept pulse with a source number, the block commits the whole entry sequence at that clock edge. In the same edge it saves the resume address and the status word, records an exception code, sets the disable flag, clears the pending flag and redirects the program counter to the handler of that source.

The instruction decoder drives single-cycle command strobes. These enable or disable interrupts, return from an interrupt, or load the status word or the cause register from a data bus. The `int_allowed` output tells the controller whether a new interrupt may be taken. The controller must raise the accept pulse only while `int_allowed` is high, and no more than one strobe may be active in any cycle. Instruction fetch, the pipeline and memory are outside the block, so the program counter only changes on entry, return or reset.

Top module: `irq_seq`

## Requirements
- R1: After reset the program counter is 0, the status word is 0x00000001 (disable flag set), the saved PC, the saved status and the cause register are 0, and `int_allowed` is low.
- R2: `int_allowed` is high exactly when status bit 0 (interrupt disable) and status bit 2 (non-maskable in progress) are both clear. An accept pulse is presented only while it is high.
- R3: On an accepted pulse for source n, the program counter becomes 0x80 + 16·n at the next clock edge.
- R4: On an accepted pulse, the saved PC takes the value of `resume_pc` from the accept cycle.
- R5: On an accepted pulse, the saved status takes the status word as it was before the entry.
- R6: On an accepted pulse, cause bits 15:0 take 0x80 + 16·n, and cause bits 31:16 keep their value.
- R7: On an accepted pulse, status bit 0 is set, status bit 1 (exception pending) is cleared, and all other status bits keep their value.
- R8: `cmd_ei` clears status bit 0 and `cmd_di` sets it. Neither command changes any other status bit.
- R9: `cmd_reti` loads the program counter from the saved PC and the status word from the saved status at a single clock edge.
- R10: `cmd_wr_psw` loads the whole status word from `wr_data`, and `cmd_wr_cause` loads the whole cause register from `wr_data`. At most one of the accept pulse and the command strobes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Accept pulse from the interrupt controller |
| acc_src | input | SRC_W (6) | Source number of the accepted interrupt |
| resume_pc | input | DATA_W (32) | Address at which to resume after the handler |
| cmd_ei | input | 1 | Enable-interrupts command strobe |
| cmd_di | input | 1 | Disable-interrupts command strobe |
| cmd_reti | input | 1 | Return-from-interrupt command strobe |
| cmd_wr_psw | input | 1 | Load status word from wr_data |
| cmd_wr_cause | input | 1 | Load cause register from wr_data |
| wr_data | input | DATA_W (32) | Data for the register load commands |
| int_allowed | output | 1 | A new interrupt may be accepted |
| pc | output | DATA_W (32) | Program counter |
| psw | output | DATA_W (32) | Status word |
| save_pc | output | DATA_W (32) | Saved return address |
| save_psw | output | DATA_W (32) | Saved status word |
| cause | output | DATA_W (32) | Cause register |

## Verification
The assertions check every cycle that the entry updates follow an accepted pulse at the next edge. These are the handler address, both save registers, the cause halves and the two status flags. They also check that enable, disable and return change only what they should, and that the controller never sends an accept pulse while acceptance is blocked and never sends two strobes at once. Only the bench scenarios show the effects that depend on a sequence of steps. Examples are a return restoring a status word that had bits set by an earlier load, the non-maskable flag keeping acceptance blocked across an enable command, and the upper cause bits surviving several entries.

// File: rtl/irq_seq_pkg.sv
// Shared constants of the interrupt entry/return sequencer.
// Assumes status flag positions are fixed for the whole core.
package irq_seq_pkg;
    localparam int FLAG_DIS   = 0;      // interrupts disabled
    localparam int FLAG_PEND  = 1;      // exception pending
    localparam int FLAG_NMI   = 2;      // non-maskable service in progress
    localparam int CODE_BASE  = 'h80;   // exception code of source 0
    localparam int CODE_SHIFT = 4;      // code stride is 16 per source
endpackage

// File: rtl/irq_seq_status.sv
// Status word register with acceptance gating.
// Assumes at most one of take/reti/wr/di/ei per cycle; take wins if not.
module irq_seq_status #(
    parameter int          DATA_W  = 32,
    parameter logic [31:0] PSW_RST = 32'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              reti_i,
    input  logic [DATA_W-1:0] restore_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              di_i,
    input  logic              ei_i,
    output logic [DATA_W-1:0] psw_o,
    output logic              allowed_o
);
    import irq_seq_pkg::*;

    logic [DATA_W-1:0] psw_q;
    logic [DATA_W-1:0] psw_d;

    // Next status word from the active command.
    always_comb begin
        psw_d = psw_q;
        if (take_i) begin
            psw_d[FLAG_DIS]  = 1'b1;
            psw_d[FLAG_PEND] = 1'b0;
        end else if (reti_i) begin
            psw_d = restore_i;
        end else if (wr_i) begin
            psw_d = wr_data_i;
        end else if (di_i) begin
            psw_d[FLAG_DIS] = 1'b1;
        end else if (ei_i) begin
            psw_d[FLAG_DIS] = 1'b0;
        end
    end

    // Status word register.
    always_ff @(posedge clk) begin
        if (!rst_n) psw_q <= PSW_RST[DATA_W-1:0];
        else        psw_q <= psw_d;
    end

    // Acceptance needs both blocking flags clear.
    always_comb allowed_o = !(psw_q[FLAG_DIS] || psw_q[FLAG_NMI]);

    assign psw_o = psw_q;
endmodule

// File: rtl/irq_seq_save.sv
// Save registers for return address and status word.
// Assumes they are only written on interrupt entry.
module irq_seq_save #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] psw_i,
    output logic [DATA_W-1:0] save_pc_o,
    output logic [DATA_W-1:0] save_psw_o
);
    // Capture return address and pre-entry status on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_pc_o  <= '0;
            save_psw_o <= '0;
        end else if (take_i) begin
            save_pc_o  <= pc_i;
            save_psw_o <= psw_i;
        end
    end
endmodule

// File: rtl/irq_seq_vector.sv
// Exception code and handler address per source, plus cause register.
// Assumes DATA_W > CODE_W and the code of the largest source fits CODE_W.
module irq_seq_vector #(
    parameter int SRC_W  = 6,
    parameter int DATA_W = 32,
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] handler_o,
    output logic [DATA_W-1:0] cause_o
);
    import irq_seq_pkg::*;

    localparam int HI_W = DATA_W - CODE_W;

    logic [CODE_W-1:0] code;

    // Code grows by a fixed stride from a base per source number.
    always_comb code = CODE_W'(CODE_BASE) + (CODE_W'(src_i) << CODE_SHIFT);

    // Handler sits at the code used as an offset from address zero.
    always_comb handler_o = {{HI_W{1'b0}}, code};

    // Cause register: low half from entry, full word from a load.
    always_ff @(posedge clk) begin
        if (!rst_n)       cause_o <= '0;
        else if (take_i)  cause_o <= {cause_o[DATA_W-1:CODE_W], code};
        else if (wr_i)    cause_o <= wr_data_i;
    end
endmodule

// File: rtl/irq_seq.sv
// Interrupt entry and return sequencer top level.
// Assumes accept arrives only while int_allowed is high and that at most
// one strobe is active per cycle; a blocked accept is ignored.
module irq_seq #(
    parameter int          SRC_N   = 64,
    parameter int          DATA_W  = 32,
    parameter int          CODE_W  = 16,
    parameter logic [31:0] PC_RST  = 32'h0,
    parameter logic [31:0] PSW_RST = 32'h1,
    parameter int          SRC_W   = $clog2(SRC_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [SRC_W-1:0]  acc_src,
    input  logic [DATA_W-1:0] resume_pc,
    input  logic              cmd_ei,
    input  logic              cmd_di,
    input  logic              cmd_reti,
    input  logic              cmd_wr_psw,
    input  logic              cmd_wr_cause,
    input  logic [DATA_W-1:0] wr_data,
    output logic              int_allowed,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] psw,
    output logic [DATA_W-1:0] save_pc,
    output logic [DATA_W-1:0] save_psw,
    output logic [DATA_W-1:0] cause
);
    logic              take;
    logic [DATA_W-1:0] handler;
    logic [DATA_W-1:0] pc_q;

    // Entry happens only for an accept while acceptance is open.
    always_comb take = acc_valid && int_allowed;

    irq_seq_status #(.DATA_W(DATA_W), .PSW_RST(PSW_RST)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .reti_i    (cmd_reti),
        .restore_i (save_psw),
        .wr_i      (cmd_wr_psw),
        .wr_data_i (wr_data),
        .di_i      (cmd_di),
        .ei_i      (cmd_ei),
        .psw_o     (psw),
        .allowed_o (int_allowed)
    );

    irq_seq_save #(.DATA_W(DATA_W)) u_save (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .pc_i       (resume_pc),
        .psw_i      (psw),
        .save_pc_o  (save_pc),
        .save_psw_o (save_psw)
    );

    irq_seq_vector #(.SRC_W(SRC_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .src_i     (acc_src),
        .wr_i      (cmd_wr_cause),
        .wr_data_i (wr_data),
        .handler_o (handler),
        .cause_o   (cause)
    );

    // Program counter: redirected on entry, restored on return.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= PC_RST[DATA_W-1:0];
        else if (take)     pc_q <= handler;
        else if (cmd_reti) pc_q <= save_pc;
    end

    assign pc = pc_q;
endmodule

// File: rtl/irq_seq_chk.sv
// Property checker for irq_seq, attached by bind.
// Assumes default status flag positions from the package.
module irq_seq_chk #(
    parameter int SRC_W  = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [SRC_W-1:0]  acc_src,
    input logic [DATA_W-1:0] resume_pc,
    input logic              cmd_ei,
    input logic              cmd_di,
    input logic              cmd_reti,
    input logic              cmd_wr_psw,
    input logic              cmd_wr_cause,
    input logic [DATA_W-1:0] wr_data,
    input logic              int_allowed,
    input logic [DATA_W-1:0] pc,
    input logic [DATA_W-1:0] psw,
    input logic [DATA_W-1:0] save_pc,
    input logic [DATA_W-1:0] save_psw,
    input logic [DATA_W-1:0] cause
);
    logic [15:0] exp_code;
    always_comb exp_code = 16'h0080 + (16'(acc_src) << 4);

    // R2: controller contract, accept only while open
    a_r2_accept_only_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> int_allowed);
    // R10: one strobe per cycle
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_valid, cmd_ei, cmd_di, cmd_reti, cmd_wr_psw, cmd_wr_cause}));
    // R3
    a_r3_handler_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && int_allowed) |=> pc == DATA_W'($past(exp_code)));
    // R4
    a_r4_save_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && int_allowed) |=> save_pc == $past(resume_pc));
    // R5
    a_r5_save_status: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && int_allowed) |=> save_psw == $past(psw));
    // R6
    a_r6_cause_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && int_allowed) |=>
            (cause[15:0] == $past(exp_code)) && (cause[DATA_W-1:16] == $past(cause[DATA_W-1:16])));
    // R7
    a_r7_entry_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && int_allowed) |=>
            psw[0] && !psw[1] && (psw[DATA_W-1:2] == $past(psw[DATA_W-1:2])));
    // R8: enable
    a_r8_enable: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ei |=> !psw[0] && (psw[DATA_W-1:1] == $past(psw[DATA_W-1:1])));
    // R8: disable
    a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_di |=> psw[0] && (psw[DATA_W-1:1] == $past(psw[DATA_W-1:1])));
    // R9
    a_r9_return: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reti |=> (pc == $past(save_pc)) && (psw == $past(save_psw)));
    // R10: loads
    a_r10_load_status: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_psw |=> psw == $past(wr_data));
    a_r10_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_cause |=> cause == $past(wr_data));
endmodule

bind irq_seq irq_seq_chk #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_src(acc_src),
    .resume_pc(resume_pc), .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_reti(cmd_reti),
    .cmd_wr_psw(cmd_wr_psw), .cmd_wr_cause(cmd_wr_cause), .wr_data(wr_data),
    .int_allowed(int_allowed), .pc(pc), .psw(psw), .save_pc(save_pc),
    .save_psw(save_psw), .cause(cause)
);

// File: tb/irq_seq_tb.sv
module irq_seq_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        string       tag;
        logic        allowed;
        logic [31:0] pc, psw, spc, spsw, cause;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        acc_valid = 0;
    logic [5:0]  acc_src = 0;
    logic [31:0] resume_pc = 0;
    logic        cmd_ei = 0, cmd_di = 0, cmd_reti = 0, cmd_wr_psw = 0, cmd_wr_cause = 0;
    logic [31:0] wr_data = 0;
    logic        int_allowed;
    logic [31:0] pc, psw, save_pc, save_psw, cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    exp_t q[$];
    logic [31:0] m_pc, m_psw, m_spc, m_spsw, m_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_seq u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_src(acc_src),
        .resume_pc(resume_pc), .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_reti(cmd_reti),
        .cmd_wr_psw(cmd_wr_psw), .cmd_wr_cause(cmd_wr_cause), .wr_data(wr_data),
        .int_allowed(int_allowed), .pc(pc), .psw(psw), .save_pc(save_pc),
        .save_psw(save_psw), .cause(cause)
    );

    function automatic void cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endfunction

    function automatic void push(string tag);
        exp_t e;
        e.tag = tag;
        e.allowed = !(m_psw[0] || m_psw[2]);
        e.pc = m_pc; e.psw = m_psw; e.spc = m_spc; e.spsw = m_spsw; e.cause = m_cause;
        q.push_back(e);
    endfunction

    // Driver: one strobe for one cycle, then queue the expected state.
    task automatic op(string kind, string tag, logic [5:0] src = 0, logic [31:0] val = 0);
        logic [15:0] code;
        @(negedge clk);
        code = 16'h80 + 16'(src) * 16'd16;
        case (kind)
            "acc": begin
                acc_valid = 1; acc_src = src; resume_pc = val;
                m_spc = val; m_spsw = m_psw; m_pc = {16'h0, code};
                m_cause = {m_cause[31:16], code};
                m_psw = (m_psw | 32'h1) & ~32'h2;
            end
            "ei":    begin cmd_ei = 1; m_psw[0] = 0; end
            "di":    begin cmd_di = 1; m_psw[0] = 1; end
            "reti":  begin cmd_reti = 1; m_pc = m_spc; m_psw = m_spsw; end
            "wpsw":  begin cmd_wr_psw = 1; wr_data = val; m_psw = val; end
            "wcause":begin cmd_wr_cause = 1; wr_data = val; m_cause = val; end
            default: ;
        endcase
        @(posedge clk);
        #1;
        acc_valid = 0; cmd_ei = 0; cmd_di = 0; cmd_reti = 0;
        cmd_wr_psw = 0; cmd_wr_cause = 0;
        push(tag);
    endtask

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "allowed", {31'h0, int_allowed}, {31'h0, e.allowed});
            cmp(e.tag, "pc", pc, e.pc);
            cmp(e.tag, "psw", psw, e.psw);
            cmp(e.tag, "save_pc", save_pc, e.spc);
            cmp(e.tag, "save_psw", save_psw, e.spsw);
            cmp(e.tag, "cause", cause, e.cause);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        m_pc = 0; m_psw = 32'h1; m_spc = 0; m_spsw = 0; m_cause = 0;
        cmp("R1", "pc", pc, 0);
        cmp("R1", "psw", psw, 32'h1);
        cmp("R1", "save_pc", save_pc, 0);
        cmp("R1", "save_psw", save_psw, 0);
        cmp("R1", "cause", cause, 0);
        cmp("R1", "allowed", {31'h0, int_allowed}, 0);

        op("wcause", "R10 load cause", 0, 32'hABCD_0000);
        op("ei", "R8 enable");
        op("acc", "R3 R4 R6 entry src0", 6'd0, 32'h0000_1000);
        op("ei", "R8 enable in handler");
        op("acc", "R3 R5 entry src63", 6'd63, 32'h0000_2004);
        op("reti", "R9 return");
        op("wpsw", "R10 load status with pending", 0, 32'h0000_00F2);
        op("acc", "R7 entry clears pending", 6'd5, 32'h0000_3008);
        op("reti", "R9 return restores pending", 0, 0);
        op("wpsw", "R2 non-maskable blocks", 0, 32'h0000_0004);
        op("ei", "R2 enable keeps block");
        op("di", "R8 disable");
        op("wpsw", "R2 open again", 0, 32'h8000_0000);
        for (int i = 1; i < 63; i += 13) begin
            op("acc", "R6 entry sweep", 6'(i), 32'h4000_0000 + i);
            op("reti", "R9 sweep return");
        end
        op("wcause", "R10 cause full word", 0, 32'h1234_5678);
        op("acc", "R6 upper half kept", 6'd17, 32'h0000_5000);
        op("idle", "R9 hold after entry");
        repeat (3) @(negedge clk);
        done = 1;
    end

    // Watchdog and end of run.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule